// File: doc/BRIEF.md
# Rotating-Buffer Sieve Event Scheduler

This block schedules sieve contributions from arithmetic progressions whose intervals are large. Each of these progressions fires only rarely. A pending event pairs an interval `p` with the sieve index `a` at which the progression next contributes. Events are held in a circular slot memory, and the slot an event sits in is chosen by its index: an event for index `a` lives in slot `(a >> S_LOG) mod DEPTH`, where `S = 2**S_LOG` is the number of sieve indices the downstream pipeline accepts per clock.

While `run` is high, a read head steps through one slot per clock. If the slot under the head holds an event, the block emits a contribution one cycle later. That contribution carries:
- the event's weight, and
- the lane `a mod S`.

In the same cycle the block advances the event to `a + p` and writes it back ahead of the head, into the slot for its new index. The memory therefore acts as a priority queue ordered by index without any sorting.

If that slot is already taken, the event slides into the first free slot of a short slack window. If the whole window is full, the event is dropped and a sticky overflow flag is raised. Software fills the memory through an init port while `run` is low. Correct scheduling assumes `S <= p < (DEPTH - SLACK) * S`.

Top module: `sieve_event_sched`

## Requirements
- R1: After reset, `out_valid` and `overflow` are 0 and every slot is empty.
- R2: While `run` is 0, a pulse of `init_en` stores the event (`init_p`, `init_a`, `init_w`) in slot `init_slot`. While `run` is 1, `init_en` has no effect.
- R3: While `run` is 1, the read head advances one slot per clock and wraps from DEPTH-1 to 0, starting at slot 0 after reset. While `run` is 0, the head holds its position and `out_valid` is 0.
- R4: The clock after the head reads a slot, `out_valid` is 1 if that slot held an event. In that case `out_lane` equals the low S_LOG bits of the event's index `a`, and `out_w` equals its weight. An empty slot gives `out_valid` = 0.
- R5: An emitted event is rewritten with index `a + p` into slot `((a + p) >> S_LOG) mod DEPTH`. Absent collisions, an event with index `a` is therefore emitted on head step `floor(a / S)`, counting steps from 0 after reset.
- R6: A slot counts as busy if it holds an event or is under the head. When the target slot is busy, the event goes to the first free slot among target+1, target+2 and target+3, taken in that order.
- R7: When all four slots of the window are busy, the event is dropped and `overflow` rises on the next clock. It then stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Head advances and sieving proceeds while high |
| init_en | input | 1 | Store an event in a slot (only while `run` is low) |
| init_slot | input | D_LOG | Slot to store into |
| init_p | input | PW | Progression interval |
| init_a | input | AW | Next sieve index of the progression |
| init_w | input | WW | Log weight of the progression |
| out_valid | output | 1 | Contribution strobe |
| out_lane | output | S_LOG | Pipeline lane, index mod S |
| out_w | output | WW | Contribution weight |
| overflow | output | 1 | Sticky flag: an event found no free slot |

## Verification
A single progression is run through more than one full revolution of the memory. Its hits must fall exactly on step `floor(a/S)` with the right lane, which separates a correct slot formula and wrap from an off-by-one head or a bad target computation. Three progressions are then aimed at the same slot, and the order in which their weights come out shows whether the slack search takes the first free slot in increasing order. A full slack window checks that the event is dropped and the flag is sticky. A pause in `run` and an init pulse issued while running check that the head holds its position and that the init port is ignored during sieving.

// File: rtl/sieve_event_sched.sv
module sieve_event_sched #(
  parameter int S_LOG = 5,
  parameter int D_LOG = 6,
  parameter int PW    = 20,
  parameter int AW    = 32,
  parameter int WW    = 8,
  parameter int SLACK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             init_en,
  input  logic [D_LOG-1:0] init_slot,
  input  logic [PW-1:0]    init_p,
  input  logic [AW-1:0]    init_a,
  input  logic [WW-1:0]    init_w,
  output logic             out_valid,
  output logic [S_LOG-1:0] out_lane,
  output logic [WW-1:0]    out_w,
  output logic             overflow
);
  localparam int DEPTH = 1 << D_LOG;

  logic [DEPTH-1:0] vld;
  logic [PW-1:0]    mem_p [DEPTH];
  logic [AW-1:0]    mem_a [DEPTH];
  logic [WW-1:0]    mem_w [DEPTH];
  logic [D_LOG-1:0] rp;

  wire              cur_v  = run && vld[rp];
  wire [AW-1:0]     next_a = mem_a[rp] + AW'(mem_p[rp]);
  wire [D_LOG-1:0]  tgt    = next_a[S_LOG +: D_LOG];

  logic [D_LOG-1:0] cand [SLACK];
  logic [SLACK-1:0] busy;
  logic             found;
  logic [D_LOG-1:0] sel;

  for (genvar k = 0; k < SLACK; k++) begin : g_win
    assign cand[k] = tgt + D_LOG'(k);
    assign busy[k] = vld[cand[k]] || (cand[k] == rp);
  end

  always_comb begin
    found = 1'b0;
    sel   = tgt;
    for (int k = SLACK - 1; k >= 0; k--) begin
      if (!busy[k]) begin
        found = 1'b1;
        sel   = cand[k];
      end
    end
  end

  wire             wr_run  = cur_v && found;
  wire             wr_init = !run && init_en;
  wire             wr_en   = wr_run || wr_init;
  wire [D_LOG-1:0] wr_slot = run ? sel : init_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp        <= '0;
      vld       <= '0;
      out_valid <= 1'b0;
      out_lane  <= '0;
      out_w     <= '0;
      overflow  <= 1'b0;
    end else begin
      out_valid <= cur_v;
      out_lane  <= mem_a[rp][S_LOG-1:0];
      out_w     <= mem_w[rp];
      if (run) begin
        rp <= rp + 1'b1;
        if (cur_v) begin
          vld[rp] <= 1'b0;
          if (found) vld[sel] <= 1'b1;
          else       overflow <= 1'b1;
        end
      end else if (init_en) begin
        vld[init_slot] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_p[wr_slot] <= run ? mem_p[rp] : init_p;
      mem_a[wr_slot] <= run ? next_a    : init_a;
      mem_w[wr_slot] <= run ? mem_w[rp] : init_w;
    end
  end
endmodule

// File: rtl/sieve_sched_chk.sv
module sieve_sched_chk #(
  parameter int D_LOG = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             out_valid,
  input logic             overflow,
  input logic [D_LOG-1:0] rp
);
  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> rp == $past(rp) + 1'b1); // R3
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(rp)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !out_valid); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R7
  AST_OVF_WHEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(run)); // R7
endmodule

bind sieve_event_sched sieve_sched_chk #(.D_LOG(D_LOG)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run),
  .out_valid(out_valid), .overflow(overflow), .rp(rp)
);

// File: tb/tb_sieve_event_sched.sv
`timescale 1ns/1ps
module tb_sieve_event_sched;
  localparam int S_LOG = 3;
  localparam int D_LOG = 4;
  localparam int PW = 20, AW = 32, WW = 8;

  logic clk = 0, rst_n = 0, run = 0, init_en = 0;
  logic [D_LOG-1:0] init_slot = '0;
  logic [PW-1:0] init_p = '0;
  logic [AW-1:0] init_a = '0;
  logic [WW-1:0] init_w = '0;
  logic out_valid, overflow;
  logic [S_LOG-1:0] out_lane;
  logic [WW-1:0] out_w;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sieve_event_sched #(.S_LOG(S_LOG), .D_LOG(D_LOG), .PW(PW), .AW(AW), .WW(WW)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .init_en(init_en), .init_slot(init_slot),
    .init_p(init_p), .init_a(init_a), .init_w(init_w), .out_valid(out_valid),
    .out_lane(out_lane), .out_w(out_w), .overflow(overflow));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp=<20000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; run = 0; init_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic load(input int slot, input int p, input int a, input int w);
    @(negedge clk);
    init_en = 1; init_slot = D_LOG'(slot); init_p = PW'(p); init_a = AW'(a); init_w = WW'(w);
    @(negedge clk);
    init_en = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(out_valid == 0, "R1 valid after reset", out_valid, 0);
    chk(overflow == 0, "R1 overflow after reset", overflow, 0);
    run = 1;
    begin
      int hits = 0;
      for (int i = 0; i < 20; i++) begin step(); if (out_valid) hits++; end
      chk(hits == 0, "R1 slots empty after reset", hits, 0);
    end
    run = 0;
  endtask

  task automatic t_single();
    int ea, strays, p;
    p = 43; ea = 3; strays = 0;
    do_reset();
    load(0, p, ea, 8'h5A);
    run = 1;
    for (int s = 0; s < 40; s++) begin
      step();
      if (s == (ea >> S_LOG)) begin
        chk(out_valid == 1, "R5 hit on step a/S", out_valid, 1);
        chk(out_lane == (ea & 7), "R4 lane a mod S", out_lane, ea & 7);
        chk(out_w == 8'h5A, "R4 weight", out_w, 8'h5A);
        ea += p;
      end else if (out_valid) strays++;
    end
    chk(strays == 0, "R4 empty slots silent", strays, 0);
    chk(overflow == 0, "R7 no overflow single", overflow, 0);
    run = 0;
  endtask

  task automatic t_collision();
    do_reset();
    load(0, 41, 1, 8'hA1);
    load(1, 33, 10, 8'hB2);
    load(2, 22, 20, 8'hC3);
    run = 1;
    for (int s = 0; s < 8; s++) begin
      step();
      if (s == 5) begin
        chk(out_valid && out_w == 8'hA1, "R6 target slot first", out_w, 8'hA1);
        chk(out_lane == 2, "R6 lane A", out_lane, 2);
      end
      if (s == 6) begin
        chk(out_valid && out_w == 8'hB2, "R6 slack +1", out_w, 8'hB2);
        chk(out_lane == 3, "R6 lane B", out_lane, 3);
      end
      if (s == 7) chk(out_valid && out_w == 8'hC3, "R6 slack +2", out_w, 8'hC3);
    end
    run = 0;
  endtask

  task automatic t_overflow();
    int seen;
    seen = 0;
    do_reset();
    load(0, 40, 0, 8'hEE);
    for (int k = 0; k < 4; k++) load(5 + k, 64, 40 + 8 * k, 8'h10 + k);
    chk(overflow == 0, "R7 clear before run", overflow, 0);
    run = 1;
    step();
    chk(overflow == 1, "R7 overflow raised", overflow, 1);
    for (int s = 1; s < 24; s++) begin
      step();
      if (out_valid && out_w == 8'hEE) seen++;
      if (s >= 5 && s <= 8)
        chk(out_valid && out_w == WW'(8'h10 + s - 5), "R7 window events kept", out_w, 8'h10 + s - 5);
    end
    chk(seen == 0, "R7 event dropped", seen, 0);
    chk(overflow == 1, "R7 overflow sticky", overflow, 1);
    run = 0;
  endtask

  task automatic t_init_ignored();
    int seen;
    seen = 0;
    do_reset();
    load(0, 48, 0, 8'h01);
    run = 1;
    step(); step();
    init_en = 1; init_slot = 4; init_p = 64; init_a = 32; init_w = 8'h77;
    step();
    init_en = 0;
    for (int s = 3; s < 20; s++) begin
      step();
      if (out_valid && out_w == 8'h77) seen++;
      if (s == 6) chk(out_valid && out_w == 8'h01, "R5 resident event", out_w, 1);
    end
    chk(seen == 0, "R2 init ignored while running", seen, 0);
    run = 0;
    do_reset();
    load(3, 64, 24, 8'h42);
    run = 1;
    for (int s = 0; s < 4; s++) begin
      step();
      if (s == 3) chk(out_valid && out_w == 8'h42, "R2 init stores while idle", out_w, 8'h42);
    end
    run = 0;
  endtask

  task automatic t_pause();
    int q;
    q = 0;
    do_reset();
    load(2, 64, 16, 8'h03);
    run = 1;
    step();
    run = 0;
    for (int i = 0; i < 5; i++) begin step(); if (out_valid) q++; end
    chk(q == 0, "R3 quiet while paused", q, 0);
    run = 1;
    step();
    chk(out_valid == 0, "R3 head held (slot1 empty)", out_valid, 0);
    step();
    chk(out_valid && out_w == 8'h03, "R3 resumes at slot2", out_w, 3);
    chk(out_lane == 0, "R4 lane after pause", out_lane, 0);
    run = 0;
  endtask

  initial begin
    t_reset();
    t_single();
    t_collision();
    t_overflow();
    t_init_ignored();
    t_pause();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule